// File: doc/BRIEF.md
# Synchronous Burst SRAM Front End

This block is the clocked control path of a pipelined burst static RAM, with a small storage array behind it so that reads and writes can be observed. On every rising clock edge it decides whether the cycle starts a new access, continues a burst or deselects the device. When a new address is taken, its two low bits seed a two-bit linear burst counter. Later cycles can step that counter with an active-low advance input while the upper address bits stay fixed.

There are two address strobes. The processor-side strobe is honoured only when the first chip enable is low. The controller-side strobe is always honoured. The three chip enables have mixed polarity and are examined only when a strobe arrives. Writes are decided per byte lane: a global write enable writes all eight 9-bit lanes, and otherwise a byte-write enable combined with the per-lane selects chooses the lanes. A cycle that writes nothing is a read, and the word appears on a registered output one cycle later.

Top module: `burst_sram_front`

## Requirements
- R1: While reset is asserted and until the first accepted strobe, `rd_valid_o` is 0 and `rd_data_o` is all zeros.
- R2: A strobe is accepted when `strb_ctl_n` is low, or when `strb_cpu_n` is low with `cen_a_n` low. If the chip enables are active at the same time (`cen_a_n`=0, `cen_b`=1, `cen_c_n`=0), `addr_i` is loaded and that cycle accesses `addr_i` itself.
- R3: When `cen_a_n` is high, a low `strb_cpu_n` has no effect. With `strb_ctl_n` high, the cycle behaves as a burst-continue cycle.
- R4: An accepted strobe with any chip enable inactive deselects the block. Until the next strobe with active enables, no lane is written, `burst_step_n` has no effect, and `rd_valid_o` stays 0 with `rd_data_o` all zeros.
- R5: On a continue cycle (no accepted strobe, block selected), `burst_step_n`=0 advances the low two address bits in the order 0,1,2,3,0 before the access, and `burst_step_n`=1 repeats the current address. The upper bits never change during a burst, and the chip enables are ignored on these cycles.
- R6: `all_wr_n`=0 on an active cycle writes all eight lanes from `wr_data_i`, whatever `lane_wr_en_n` and `lane_sel_n` hold.
- R7: With `all_wr_n`=1 and `lane_wr_en_n`=0, lane k (bits 9k+8 down to 9k of the word) is written exactly when `lane_sel_n[k]`=0. The other lanes keep their contents.
- R8: An active cycle that writes no lane is a read: on the next cycle `rd_valid_o`=1 and `rd_data_o` holds the addressed word.
- R9: On a cycle where the processor-side strobe is accepted with active enables, nothing is written even if `strb_ctl_n` and the write inputs are also low, and the cycle is a read.
- R10: The cycle after a write, `rd_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W (6) | Word address, low two bits seed the burst counter |
| cen_a_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| cen_b | input | 1 | Chip enable, active high |
| cen_c_n | input | 1 | Chip enable, active low |
| strb_cpu_n | input | 1 | Processor-side address strobe, active low |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| burst_step_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Global write, active low |
| lane_wr_en_n | input | 1 | Byte-write enable, active low |
| lane_sel_n | input | LANES (8) | Per-lane write selects, active low |
| wr_data_i | input | LANES*LANE_W (72) | Write data |
| rd_data_o | output | LANES*LANE_W (72) | Registered read data, zero when not valid |
| rd_valid_o | output | 1 | Read data valid |

## Verification
Two functions can fall in the same cycle. The first pair is a processor-strobe load and a write request: both strobes are driven low together with the global write low. The bench then checks that the cycle returns the old word and that a later read shows it unchanged. The second pair is a burst advance and a chip-enable change: an enable is dropped during a continue cycle and the bench confirms the counter still steps and data still flows. A behavioural model with its own memory predicts `rd_valid_o` and `rd_data_o` for every clock, including a long stretch of random strobe, advance and lane-select patterns.

// File: rtl/sram_fe_pkg.sv
package sram_fe_pkg;
   localparam int BURST_BITS = 2;

   typedef logic [BURST_BITS-1:0] burst_cnt_t;

   function automatic burst_cnt_t burst_next(input burst_cnt_t c);
      return burst_cnt_t'(c + burst_cnt_t'(1));
   endfunction
endpackage

// File: rtl/sram_addr_ctrl.sv
module sram_addr_ctrl
   import sram_fe_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              cen_a_n,
   input  logic              cen_b,
   input  logic              cen_c_n,
   input  logic              strb_cpu_n,
   input  logic              strb_ctl_n,
   input  logic              burst_step_n,
   output logic [ADDR_W-1:0] eff_addr_o,
   output logic              active_o,
   output logic              cpu_load_o
);
   localparam int UP_W = ADDR_W - BURST_BITS;

   logic              cpu_take, ctl_take, strobe, en_ok, load;
   logic              sel_q;
   logic [UP_W-1:0]   up_q;
   burst_cnt_t        cnt_q;

   assign cpu_take = !strb_cpu_n && !cen_a_n;
   assign ctl_take = !strb_ctl_n;
   assign strobe   = cpu_take || ctl_take;
   assign en_ok    = !cen_a_n && cen_b && !cen_c_n;
   assign load     = strobe && en_ok;

   always_comb begin
      if (load)
         eff_addr_o = addr_i;
      else if (!burst_step_n)
         eff_addr_o = {up_q, burst_next(cnt_q)};
      else
         eff_addr_o = {up_q, cnt_q};
   end

   assign active_o   = load || (!strobe && sel_q);
   assign cpu_load_o = load && cpu_take;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= 1'b0;
         up_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (strobe)
            sel_q <= en_ok;
         if (active_o)
            {up_q, cnt_q} <= eff_addr_o;
      end
   end

   AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> ({up_q, cnt_q} == $past(addr_i)));                     // R2
   AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> $stable(up_q));                                     // R5
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe && sel_q && !burst_step_n) |=>
         (cnt_q == burst_cnt_t'($past(cnt_q) + burst_cnt_t'(1))));   // R5
   AST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && !en_ok) |=> !sel_q);                                 // R4
endmodule

// File: rtl/sram_lane_decode.sv
module sram_lane_decode #(
   parameter int LANES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active_i,
   input  logic             cpu_load_i,
   input  logic             all_wr_n,
   input  logic             lane_wr_en_n,
   input  logic [LANES-1:0] lane_sel_n,
   output logic [LANES-1:0] wr_en_o,
   output logic             wr_any_o
);
   logic write_ok;

   assign write_ok = active_i && !cpu_load_i;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign wr_en_o[g] = write_ok && (!all_wr_n || (!lane_wr_en_n && !lane_sel_n[g]));
   end

   assign wr_any_o = |wr_en_o;

   AST_CPU_FIRST_READ: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_load_i |-> (wr_en_o == '0));                                // R9
   AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !active_i |-> !wr_any_o);                                       // R4
   AST_GLOBAL_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (write_ok && !all_wr_n) |-> (&wr_en_o));                        // R6
endmodule

// File: rtl/sram_store.sv
module sram_store #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 8,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic                    active_i,
   input  logic [LANES-1:0]        wr_en_i,
   input  logic                    wr_any_i,
   input  logic [LANES*LANE_W-1:0] wr_data_i,
   output logic [LANES*LANE_W-1:0] rd_data_o,
   output logic                    rd_valid_o
);
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int DATA_W = LANES * LANE_W;

   logic [DATA_W-1:0] word;
   logic              rd_now;

   for (genvar g = 0; g < LANES; g++) begin : g_bank
      logic [LANE_W-1:0] mem_q [DEPTH];
      always_ff @(posedge clk) begin
         if (wr_en_i[g])
            mem_q[addr_i] <= wr_data_i[g*LANE_W +: LANE_W];
      end
      assign word[g*LANE_W +: LANE_W] = mem_q[addr_i];
   end

   assign rd_now = active_i && !wr_any_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data_o  <= '0;
         rd_valid_o <= 1'b0;
      end else begin
         rd_data_o  <= rd_now ? word : '0;
         rd_valid_o <= rd_now;
      end
   end

   AST_WRITE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      wr_any_i |=> !rd_valid_o);                                      // R10
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid_o |-> (rd_data_o == '0));                             // R1
   AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i && !wr_any_i) |=> rd_valid_o);                        // R8
endmodule

// File: rtl/burst_sram_front.sv
module burst_sram_front #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 8,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic                    cen_a_n,
   input  logic                    cen_b,
   input  logic                    cen_c_n,
   input  logic                    strb_cpu_n,
   input  logic                    strb_ctl_n,
   input  logic                    burst_step_n,
   input  logic                    all_wr_n,
   input  logic                    lane_wr_en_n,
   input  logic [LANES-1:0]        lane_sel_n,
   input  logic [LANES*LANE_W-1:0] wr_data_i,
   output logic [LANES*LANE_W-1:0] rd_data_o,
   output logic                    rd_valid_o
);
   if (ADDR_W < 3 || ADDR_W > 12) begin : g_bad_addr
      $error("burst_sram_front: ADDR_W must lie in 3..12");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("burst_sram_front: LANES must be at least 1");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("burst_sram_front: LANE_W must be at least 1");
   end

   logic [ADDR_W-1:0] eff_addr;
   logic              active, cpu_load, wr_any;
   logic [LANES-1:0]  wr_en;

   sram_addr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
      .cen_a_n(cen_a_n), .cen_b(cen_b), .cen_c_n(cen_c_n),
      .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n),
      .burst_step_n(burst_step_n),
      .eff_addr_o(eff_addr), .active_o(active), .cpu_load_o(cpu_load)
   );

   sram_lane_decode #(.LANES(LANES)) u_dec (
      .clk(clk), .rst_n(rst_n), .active_i(active), .cpu_load_i(cpu_load),
      .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
      .wr_en_o(wr_en), .wr_any_o(wr_any)
   );

   sram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
      .clk(clk), .rst_n(rst_n), .addr_i(eff_addr), .active_i(active),
      .wr_en_i(wr_en), .wr_any_i(wr_any), .wr_data_i(wr_data_i),
      .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
   );
endmodule

// File: tb/tb_burst_sram_front.sv
`timescale 1ns/1ps
module tb_burst_sram_front;
   localparam int AW = 6, NL = 8, LW = 9, DW = NL*LW, DEPTH = 1 << AW;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          c1n = 1'b0, c2 = 1'b1, c3n = 1'b0;
   logic          cpu_n = 1'b1, ctl_n = 1'b1, step_n = 1'b1;
   logic          gwn = 1'b1, bwen = 1'b1;
   logic [NL-1:0] bwn = '1;
   logic [DW-1:0] wd = '0;
   logic [DW-1:0] rdata;
   logic          rvalid;

   burst_sram_front #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut (
      .clk(clk), .rst_n(rst_n), .addr_i(addr),
      .cen_a_n(c1n), .cen_b(c2), .cen_c_n(c3n),
      .strb_cpu_n(cpu_n), .strb_ctl_n(ctl_n), .burst_step_n(step_n),
      .all_wr_n(gwn), .lane_wr_en_n(bwen), .lane_sel_n(bwn),
      .wr_data_i(wd), .rd_data_o(rdata), .rd_valid_o(rvalid)
   );

   int checks = 0, fails = 0;
   string cur_req = "R1";

   logic [DW-1:0] mm [DEPTH];
   bit   m_sel = 0;
   int   m_up = 0, m_cnt = 0;
   logic [DW-1:0] e_data = '0;
   bit   e_val = 0;

   function automatic logic [DW-1:0] pat(input int i);
      logic [DW-1:0] v;
      v = {NL{9'(i*37 + 5)}};
      v = v ^ (DW'(i) << 31);
      return v;
   endfunction

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_step();
      bit pt, ct, st, ok, act, first, wr;
      int a;
      pt = !cpu_n && !c1n;
      ct = !ctl_n;
      st = pt || ct;
      ok = !c1n && c2 && !c3n;
      act = 0; first = 0; a = 0;
      if (st && ok) begin
         a = int'(addr); act = 1; first = pt;
         m_up = a / 4; m_cnt = a % 4; m_sel = 1;
      end else if (st) begin
         m_sel = 0;
      end else if (m_sel) begin
         act = 1;
         if (!step_n) m_cnt = (m_cnt + 1) % 4;
         a = m_up*4 + m_cnt;
      end
      wr = act && !first && (!gwn || (!bwen && (bwn != '1)));
      e_val  = act && !wr;
      e_data = e_val ? mm[a] : '0;
      if (wr)
         for (int l = 0; l < NL; l++)
            if (!gwn || !bwn[l]) mm[a][l*LW +: LW] = wd[l*LW +: LW];
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      check(cur_req, DW'(rvalid), DW'(e_val));
      check(cur_req, rdata, e_data);
   endtask

   task automatic drive(input int a, input bit pn, input bit cn, input bit sn,
                        input bit g, input bit be, input logic [NL-1:0] bs,
                        input logic [DW-1:0] d,
                        input bit e1n = 0, input bit e2 = 1, input bit e3n = 0);
      addr = AW'(a); cpu_n = pn; ctl_n = cn; step_n = sn;
      gwn = g; bwen = be; bwn = bs; wd = d;
      c1n = e1n; c2 = e2; c3n = e3n;
      tick();
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [DW-1:0] exp10;
      for (int i = 0; i < DEPTH; i++) mm[i] = '0;
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", DW'(rvalid), '0);
      check("R1", rdata, '0);
      rst_n = 1'b1;
      cur_req = "R1";
      drive(0, 1, 1, 1, 1, 1, '1, '0);
      check("R1", DW'(rvalid), '0);

      // R6: fill every word through the global write
      cur_req = "R6";
      for (int i = 0; i < DEPTH; i++) drive(i, 1, 0, 1, 0, 1, '1, pat(i));

      // R8/R2: single read
      cur_req = "R8";
      drive(5, 1, 0, 1, 1, 1, '1, '0);
      check("R8", rdata, pat(5));
      check("R2", DW'(rvalid), DW'(1));

      // R5: burst from 6 wraps 7,4,5; enables dropped mid-burst are ignored
      cur_req = "R5";
      drive(6, 0, 1, 1, 1, 1, '1, '0);
      check("R2", rdata, pat(6));
      drive(0, 1, 1, 0, 1, 1, '1, '0);
      check("R5", rdata, pat(7));
      drive(0, 1, 1, 0, 1, 1, '1, '0);
      check("R5", rdata, pat(4));
      drive(0, 1, 1, 0, 1, 1, '1, '0, 0, 0, 1);
      check("R5", rdata, pat(5));
      drive(0, 1, 1, 1, 1, 1, '1, '0);
      check("R5", rdata, pat(5));

      // R3: processor strobe masked by high first enable -> continue
      cur_req = "R3";
      drive(40, 0, 1, 0, 1, 1, '1, '0, 1);
      check("R3", rdata, pat(6));

      // R7: byte write of lanes 0,2,4,6 then readback
      cur_req = "R7";
      drive(10, 1, 0, 1, 1, 0, 8'hAA, '1);
      check("R10", DW'(rvalid), '0);
      exp10 = pat(10);
      for (int l = 0; l < NL; l += 2) exp10[l*LW +: LW] = '1;
      drive(10, 1, 0, 1, 1, 1, '1, '0);
      check("R7", rdata, exp10);

      // R6: global write overrides deasserted byte controls
      cur_req = "R6";
      drive(11, 1, 0, 1, 0, 1, '1, {NL{9'h15A}});
      drive(11, 1, 0, 1, 1, 1, '1, '0);
      check("R6", rdata, {NL{9'h15A}});

      // R9: both strobes with global write -> read, no write
      cur_req = "R9";
      drive(20, 0, 0, 1, 0, 0, '0, '0);
      check("R9", DW'(rvalid), DW'(1));
      check("R9", rdata, pat(20));
      drive(20, 1, 0, 1, 1, 1, '1, '0);
      check("R9", rdata, pat(20));

      // R4: deselect, then write/advance attempts are ignored
      cur_req = "R4";
      drive(30, 1, 0, 1, 0, 1, '1, '0, 0, 0, 0);
      check("R4", DW'(rvalid), '0);
      drive(30, 1, 1, 0, 0, 1, '1, '0);
      check("R4", rdata, '0);
      drive(31, 1, 0, 1, 1, 1, '1, '0, 1);
      check("R4", DW'(rvalid), '0);
      drive(30, 1, 0, 1, 1, 1, '1, '0);
      check("R4", rdata, pat(30));

      // R2: random mixture judged by the model every clock
      cur_req = "R2";
      for (int n = 0; n < 400; n++) begin
         bit [7:0] r;
         r = 8'($urandom);
         drive(int'($urandom % DEPTH), r[0], r[1] | r[2], r[3],
               ($urandom % 6) != 0, r[4], NL'($urandom), {$urandom, $urandom, 8'($urandom)},
               ($urandom % 8) == 0, ($urandom % 8) != 0, ($urandom % 8) == 0);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule